// File: doc/BRIEF.md
# Readback Scrub and Partial Reload Sequencer

This block controls the lifetime of one protected configuration image. A master starts an operation with a start pulse and a word count. The block then streams the master's words into the configuration store through a single access port that both reads and writes. Each word it writes is also handed to an external check-bit encoder. The block then waits for a programmable interval and reads the whole image back through the same port, handing every word to an external corrector.

The corrector reports the word addresses where it repaired faults. The block marks the partition that holds each reported address. When the corrector finishes, the block rewrites only the marked partitions, taking the corrected words from the corrector. If the corrector reports that the faults exceeded its capacity, the block asks the master for a full reload instead. It clears its partition marks and signals completion.

The image is split into equal partitions of 2^PART_LOG2 words. The partition index is the upper ADDR_W-PART_LOG2 bits of a word address.

Top module: `scrub_seq`

## Requirements
- R1: After reset, `done`, `reload_req`, `port_valid`, `cfg_take`, `enc_valid` and `dec_valid` are all low.
- R2: After a `start` pulse in the idle state with `bit_len` = L (1 ≤ L ≤ 2^ADDR_W), the block issues exactly L port writes at addresses 0 to L-1 in ascending order. Each write carries `cfg_data`. Each accepted write raises `cfg_take` and `enc_valid` in that cycle, with `enc_data` equal to the written word.
- R3: After the last download write is accepted, the port stays idle for exactly `interval`+1 cycles, with `interval` sampled at start. The first readback request then appears.
- R4: Readback issues exactly L port reads at addresses 0 to L-1 in ascending order. Each accepted read raises `dec_valid` in the same cycle with `dec_data` equal to `port_rdata`. `enc_valid` stays low during readback.
- R5: While waiting for the interval and while waiting for `dec_done`, the block makes no port request. Reads and writes occur only in their own phases.
- R6: After `dec_done` with `dec_fail` low, every partition that received at least one fault report is rewritten in ascending partition order. Each rewrite covers all words of the partition in ascending address order, with `port_wdata` equal to `fix_data`. No other address is written.
- R7: A fault report presented in the same cycle as `dec_done` is included in the set of partitions to rewrite.
- R8: After `dec_done` with `dec_fail` high, `reload_req` is high for exactly one cycle and no rewrite write is issued. `done` follows in the next cycle.
- R9: Each operation ends with `done` high for exactly one cycle. With no fault reports and `dec_fail` low, `done` follows `dec_done` directly with no port writes.
- R10: A `start` pulse while an operation is in progress is ignored. The length and interval of the running operation are unchanged.
- R11: Partition marks are cleared after the partition is rewritten, and all marks are cleared on a reload request. A following operation with no fault reports performs no rewrite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse from the master, taken only when idle |
| bit_len | input | ADDR_W+1 | Image length in words, sampled at start |
| interval | input | TIMER_W | Wait length before readback, sampled at start |
| done | output | 1 | One-cycle completion pulse |
| reload_req | output | 1 | One-cycle request for a full reload by the master |
| cfg_data | input | DATA_W | Next download word from the master |
| cfg_take | output | 1 | Download word consumed this cycle |
| port_valid | output | 1 | Access port request |
| port_write | output | 1 | Request is a write (1) or a read (0) |
| port_addr | output | ADDR_W | Word address of the request |
| port_wdata | output | DATA_W | Write data |
| port_ready | input | 1 | Port accepts the request this cycle |
| port_rdata | input | DATA_W | Read data, valid in the accepting cycle |
| enc_valid | output | 1 | Word handed to the encoder |
| enc_data | output | DATA_W | Encoder input word |
| dec_valid | output | 1 | Readback word handed to the corrector |
| dec_data | output | DATA_W | Corrector input word |
| dec_fault_valid | input | 1 | Corrector reports a repaired fault |
| dec_fault_addr | input | ADDR_W | Word address of the reported fault |
| dec_done | input | 1 | Corrector finished this image |
| dec_fail | input | 1 | Faults exceeded correction capacity (valid with dec_done) |
| fix_data | input | DATA_W | Corrected word for the current `port_addr` during rewrite |

## Verification
Two events can land on the same edge: the corrector's final fault report and its completion signal. The block must fold that last report into its partition set before it chooses between rewrite and completion. The bench provokes this by raising the last fault report together with `dec_done` in some directed and some random operations. It judges the outcome by comparing the observed rewrite address stream with the partition set computed from all reports. A second overlap is a start pulse that arrives while an operation is running; it is judged by the readback length and the wait time, which must match the original request.

// File: rtl/scrub_pkg.sv
package scrub_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CONFIG,
    ST_WAIT,
    ST_READBACK,
    ST_DECODE,
    ST_REWRITE,
    ST_RELOAD,
    ST_DONE
  } scrub_state_e;
endpackage

// File: rtl/scrub_timer.sv
module scrub_timer #(
  parameter int TIMER_W = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [TIMER_W-1:0] load_val,
  input  logic               run,
  output logic               expired
);
  logic [TIMER_W-1:0] remain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) remain_q <= '0;
    else if (load) remain_q <= load_val;
    else if (run && remain_q != '0) remain_q <= remain_q - TIMER_W'(1);
  end

  assign expired = (remain_q == '0);
endmodule

// File: rtl/fault_table.sv
module fault_table #(
  parameter int NPART = 8,
  parameter int IDX_W = $clog2(NPART)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_en,
  input  logic [IDX_W-1:0] clr_idx,
  input  logic             clr_all,
  output logic [NPART-1:0] bits,
  output logic [IDX_W-1:0] first_idx,
  output logic             pending_with_set,
  output logic             left_after_clr
);
  function automatic logic [NPART-1:0] idx_mask(logic [IDX_W-1:0] idx);
    logic [NPART-1:0] m;
    m = '0;
    m[idx] = 1'b1;
    return m;
  endfunction

  function automatic logic [IDX_W-1:0] lowest_set(logic [NPART-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int i = NPART - 1; i >= 0; i--) begin
      if (v[i]) r = IDX_W'(i);
    end
    return r;
  endfunction

  logic [NPART-1:0] set_mask, clr_mask;

  assign set_mask = set_en ? idx_mask(set_idx) : '0;
  assign clr_mask = clr_en ? idx_mask(clr_idx) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bits <= '0;
    else if (clr_all) bits <= '0;
    else bits <= (bits & ~clr_mask) | set_mask;
  end

  assign first_idx        = lowest_set(bits);
  assign pending_with_set = |(bits | set_mask);
  assign left_after_clr   = |(bits & ~clr_mask);
endmodule

// File: rtl/scrub_seq.sv
module scrub_seq
  import scrub_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int ADDR_W    = 6,
  parameter int PART_LOG2 = 3,
  parameter int TIMER_W   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W:0]   bit_len,
  input  logic [TIMER_W-1:0] interval,
  output logic              done,
  output logic              reload_req,
  input  logic [DATA_W-1:0] cfg_data,
  output logic              cfg_take,
  output logic              port_valid,
  output logic              port_write,
  output logic [ADDR_W-1:0] port_addr,
  output logic [DATA_W-1:0] port_wdata,
  input  logic              port_ready,
  input  logic [DATA_W-1:0] port_rdata,
  output logic              enc_valid,
  output logic [DATA_W-1:0] enc_data,
  output logic              dec_valid,
  output logic [DATA_W-1:0] dec_data,
  input  logic              dec_fault_valid,
  input  logic [ADDR_W-1:0] dec_fault_addr,
  input  logic              dec_done,
  input  logic              dec_fail,
  input  logic [DATA_W-1:0] fix_data
);
  localparam int IDX_W = ADDR_W - PART_LOG2;
  localparam int NPART = 1 << IDX_W;
  localparam int LEN_W = ADDR_W + 1;

  function automatic logic scan_at_end(logic [ADDR_W-1:0] cnt, logic [LEN_W-1:0] len);
    return {1'b0, cnt} == len - LEN_W'(1);
  endfunction

  function automatic logic [IDX_W-1:0] part_of(logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:PART_LOG2];
  endfunction

  function automatic logic [ADDR_W-1:0] rewrite_addr(logic [IDX_W-1:0] p, logic [ADDR_W-1:0] cnt);
    return {p, cnt[PART_LOG2-1:0]};
  endfunction

  scrub_state_e        state_q;
  logic [ADDR_W-1:0]   word_cnt;
  logic [LEN_W-1:0]    len_q;
  logic [TIMER_W-1:0]  ivl_q;

  // named internal events
  logic cfg_accept, rd_accept, fix_accept, scan_last, part_done, fault_set;
  logic timer_expired, tbl_pending_set, tbl_left_after_clr;
  logic [NPART-1:0] fault_bits;
  logic [IDX_W-1:0] cur_part;

  assign scan_last  = scan_at_end(word_cnt, len_q);
  assign cfg_accept = (state_q == ST_CONFIG) && port_ready;
  assign rd_accept  = (state_q == ST_READBACK) && port_ready;
  assign fix_accept = (state_q == ST_REWRITE) && port_ready;
  assign part_done  = fix_accept && (word_cnt[PART_LOG2-1:0] == '1);
  assign fault_set  = dec_fault_valid &&
                      (state_q == ST_READBACK || state_q == ST_DECODE);

  scrub_timer #(.TIMER_W(TIMER_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (cfg_accept && scan_last),
    .load_val (ivl_q),
    .run      (state_q == ST_WAIT),
    .expired  (timer_expired)
  );

  fault_table #(.NPART(NPART), .IDX_W(IDX_W)) u_tbl (
    .clk              (clk),
    .rst_n            (rst_n),
    .set_en           (fault_set),
    .set_idx          (part_of(dec_fault_addr)),
    .clr_en           (part_done),
    .clr_idx          (cur_part),
    .clr_all          (state_q == ST_RELOAD),
    .bits             (fault_bits),
    .first_idx        (cur_part),
    .pending_with_set (tbl_pending_set),
    .left_after_clr   (tbl_left_after_clr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      word_cnt <= '0;
      len_q    <= '0;
      ivl_q    <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start) begin
          state_q  <= ST_CONFIG;
          len_q    <= bit_len;
          ivl_q    <= interval;
          word_cnt <= '0;
        end
        ST_CONFIG: if (cfg_accept) begin
          if (scan_last) begin
            state_q  <= ST_WAIT;
            word_cnt <= '0;
          end else word_cnt <= word_cnt + ADDR_W'(1);
        end
        ST_WAIT: if (timer_expired) state_q <= ST_READBACK;
        ST_READBACK: if (rd_accept) begin
          if (scan_last) begin
            state_q  <= ST_DECODE;
            word_cnt <= '0;
          end else word_cnt <= word_cnt + ADDR_W'(1);
        end
        ST_DECODE: if (dec_done) begin
          if (dec_fail) state_q <= ST_RELOAD;
          else if (tbl_pending_set) state_q <= ST_REWRITE;
          else state_q <= ST_DONE;
        end
        ST_REWRITE: if (fix_accept) begin
          word_cnt <= part_done ? '0 : word_cnt + ADDR_W'(1);
          if (part_done && !tbl_left_after_clr) state_q <= ST_DONE;
        end
        ST_RELOAD: state_q <= ST_DONE;
        ST_DONE:   state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    port_valid = (state_q == ST_CONFIG) || (state_q == ST_READBACK) ||
                 (state_q == ST_REWRITE);
    port_write = (state_q == ST_CONFIG) || (state_q == ST_REWRITE);
    port_addr  = (state_q == ST_REWRITE) ? rewrite_addr(cur_part, word_cnt) : word_cnt;
    port_wdata = (state_q == ST_CONFIG) ? cfg_data : fix_data;
  end

  assign cfg_take   = cfg_accept;
  assign enc_valid  = cfg_accept;
  assign enc_data   = cfg_data;
  assign dec_valid  = rd_accept;
  assign dec_data   = port_rdata;
  assign done       = (state_q == ST_DONE);
  assign reload_req = (state_q == ST_RELOAD);
endmodule

// File: rtl/scrub_seq_chk.sv
module scrub_seq_chk
  import scrub_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int PART_LOG2 = 3,
  parameter int NPART     = 8,
  parameter int IDX_W     = 3
) (
  input logic              clk,
  input logic              rst_n,
  input scrub_state_e      state_q,
  input logic              port_valid,
  input logic              port_write,
  input logic [ADDR_W-1:0] port_addr,
  input logic              done,
  input logic              reload_req,
  input logic              enc_valid,
  input logic              dec_valid,
  input logic              part_done,
  input logic [IDX_W-1:0]  cur_part,
  input logic [NPART-1:0]  fault_bits
);
  // R5
  quiet_port_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_WAIT || state_q == ST_DECODE) |-> !port_valid);

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R8
  reload_then_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reload_req |=> (done && !reload_req && !port_valid));

  // R4
  read_no_encode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dec_valid |-> (!enc_valid && port_valid && !port_write));

  // R11
  mark_cleared_chk: assert property (@(posedge clk) disable iff (!rst_n)
    part_done |=> !fault_bits[$past(cur_part)]);

  // R6
  rewrite_marked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_REWRITE && port_valid) |-> fault_bits[port_addr[ADDR_W-1:PART_LOG2]]);
endmodule

bind scrub_seq scrub_seq_chk #(
  .ADDR_W(ADDR_W), .PART_LOG2(PART_LOG2), .NPART(NPART), .IDX_W(IDX_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .state_q    (state_q),
  .port_valid (port_valid),
  .port_write (port_write),
  .port_addr  (port_addr),
  .done       (done),
  .reload_req (reload_req),
  .enc_valid  (enc_valid),
  .dec_valid  (dec_valid),
  .part_done  (part_done),
  .cur_part   (cur_part),
  .fault_bits (fault_bits)
);

// File: tb/scrub_seq_tb.sv
`timescale 1ns/1ps
module scrub_seq_tb;
  localparam int DW = 16, AW = 6, PL = 3, TW = 12;
  localparam int WORDS = 1 << AW, PW = 1 << PL;

  logic clk = 1'b0, rst_n = 1'b0;
  logic start = 1'b0, port_ready = 1'b0;
  logic [AW:0] bit_len = '0;
  logic [TW-1:0] interval = '0;
  logic [DW-1:0] cfg_data = '0, port_rdata = '0, fix_data = '0;
  logic dec_fault_valid = 1'b0, dec_done = 1'b0, dec_fail = 1'b0;
  logic [AW-1:0] dec_fault_addr = '0;
  logic done, reload_req, cfg_take, port_valid, port_write, enc_valid, dec_valid;
  logic [AW-1:0] port_addr;
  logic [DW-1:0] port_wdata, enc_data, dec_data;

  always #10 clk = ~clk;

  scrub_seq #(.DATA_W(DW), .ADDR_W(AW), .PART_LOG2(PL), .TIMER_W(TW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .bit_len(bit_len), .interval(interval),
    .done(done), .reload_req(reload_req), .cfg_data(cfg_data), .cfg_take(cfg_take),
    .port_valid(port_valid), .port_write(port_write), .port_addr(port_addr),
    .port_wdata(port_wdata), .port_ready(port_ready), .port_rdata(port_rdata),
    .enc_valid(enc_valid), .enc_data(enc_data), .dec_valid(dec_valid), .dec_data(dec_data),
    .dec_fault_valid(dec_fault_valid), .dec_fault_addr(dec_fault_addr),
    .dec_done(dec_done), .dec_fail(dec_fail), .fix_data(fix_data));

  int tests = 0, fails = 0, cyc = 0;
  bit hung = 0;
  logic [DW-1:0] mem [WORDS];
  int op = 0, phase = 0, cur_len = 0;
  int wr_cnt, rd_cnt, rw_cnt, n_rw, n_done, n_rel, n_enc, n_quiet;
  int exp_rw [WORDS];
  int flt [8];

  function automatic logic [DW-1:0] pat(int o, int k);
    return DW'((o * 32'h3B1) ^ (k * 32'h0105) ^ 32'hA5C3);
  endfunction

  function automatic logic [DW-1:0] fixp(int a);
    return DW'((a * 32'h1111) ^ 32'h0F0F);
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic tick(input bit st, input int blen, input int ivl,
                      input bit fv, input int fa, input bit dd, input bit df);
    int ex;
    @(negedge clk);
    cyc++;
    if (cyc > 150000) hung = 1;
    start = st; bit_len = (AW+1)'(blen); interval = TW'(ivl);
    dec_fault_valid = fv; dec_fault_addr = AW'(fa); dec_done = dd; dec_fail = df;
    port_ready = ($urandom % 4) != 0;
    cfg_data = pat(op, wr_cnt);
    port_rdata = mem[port_addr];
    fix_data = fixp(int'(port_addr));
    #1;
    if (done) n_done++;
    if (reload_req) n_rel++;
    if (enc_valid) n_enc++;
    if (phase == 1 && !port_valid) n_quiet++;
    if (port_valid && port_ready) begin
      if (port_write) begin
        if (phase == 0) begin
          chk(int'(port_addr) == wr_cnt && port_wdata == pat(op, wr_cnt) && cfg_take &&
              enc_valid && enc_data == port_wdata, "R2 download write", int'(port_addr), wr_cnt);
          mem[port_addr] = port_wdata;
          wr_cnt++;
          if (wr_cnt == cur_len) phase = 1;
        end else if (phase == 3) begin
          ex = (rw_cnt < n_rw) ? exp_rw[rw_cnt] : -1;
          chk(int'(port_addr) == ex && port_wdata == fixp(ex), "R6 rewrite address", int'(port_addr), ex);
          rw_cnt++;
        end else chk(0, "R5 stray write", int'(port_addr), -1);
      end else begin
        if (phase == 1) begin
          chk(int'(port_addr) == rd_cnt && dec_valid && dec_data == mem[port_addr] && !enc_valid,
              "R4 readback", int'(port_addr), rd_cnt);
          rd_cnt++;
          if (rd_cnt == cur_len) phase = 2;
        end else chk(0, "R5 stray read", int'(port_addr), -1);
      end
    end
  endtask

  task automatic run_op(input int len, input int ivl, input int nf, input bit same,
                        input bit fail, input bit busy);
    logic [7:0] mask;
    int lim;
    bit bs_sent;
    op++; phase = 0; cur_len = len;
    wr_cnt = 0; rd_cnt = 0; rw_cnt = 0; n_rw = 0;
    n_done = 0; n_rel = 0; n_enc = 0; n_quiet = 0;
    mask = '0;
    for (int i = 0; i < nf; i++) mask[flt[i] >> PL] = 1'b1;
    for (int p = 0; p < 8; p++)
      if (mask[p]) for (int k = 0; k < PW; k++) begin exp_rw[n_rw] = p * PW + k; n_rw++; end
    tick(1, len, ivl, 0, 0, 0, 0);
    lim = 0; bs_sent = 0;
    while (phase < 2 && lim < 4000 && !hung) begin
      if (phase == 1 && busy && !bs_sent) begin
        tick(1, (len % WORDS) + 1, ivl + 3, 0, 0, 0, 0);   // R10 start while busy
        bs_sent = 1;
      end else tick(0, 0, 0, 0, 0, 0, 0);
      lim++;
    end
    chk(phase == 2, "R2 operation reached decode (watchdog)", phase, 2);
    if (phase != 2) return;
    tick(0, 0, 0, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < nf; i++)
      tick(1, 0, 0, 1, flt[i], same && (i == nf - 1), fail);
    if (!same || nf == 0) tick(0, 0, 0, 0, 0, 1, fail);
    phase = 3;
    lim = 0;
    while (n_done == 0 && lim < 4000 && !hung) begin tick(0, 0, 0, 0, 0, 0, 0); lim++; end
    tick(0, 0, 0, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 0, 0, 0);
    chk(wr_cnt == len && n_enc == len, "R2 download count", n_enc, len);
    chk(n_quiet == ivl + 1, "R3 wait length", n_quiet, ivl + 1);
    chk(rd_cnt == len, "R4/R10 readback count", rd_cnt, len);
    chk(n_done == 1, "R9 done pulse", n_done, 1);
    chk(n_rel == (fail ? 1 : 0), "R8 reload request", n_rel, fail ? 1 : 0);
    chk(rw_cnt == (fail ? 0 : n_rw), same ? "R7 rewrite count with same-cycle report" :
        (nf == 0 ? "R11 rewrite count without faults" : "R6 rewrite count"), rw_cnt, fail ? 0 : n_rw);
  endtask

  initial begin
    void'($urandom(32'h5C2B));
    for (int i = 0; i < WORDS; i++) mem[i] = '0;
    wr_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(!done && !reload_req && !port_valid && !cfg_take && !enc_valid && !dec_valid,
        "R1 reset state", {done, reload_req, port_valid, cfg_take}, 0);
    flt[0] = 5; flt[1] = 40;
    run_op(64, 3, 2, 0, 0, 0);
    run_op(10, 0, 0, 0, 0, 0);                 // R11 marks cleared after rewrite
    flt[0] = 63; flt[1] = 2; flt[2] = 60;
    run_op(1, 7, 3, 1, 0, 0);                  // R7 last report with dec_done
    flt[0] = 9;
    run_op(20, 2, 1, 0, 1, 0);                 // R8 capacity exceeded
    run_op(30, 1, 0, 0, 0, 1);                 // R11 after reload, R10 busy start
    for (int t = 0; t < 10 && !hung; t++) begin
      int nf;
      nf = $urandom % 5;
      for (int i = 0; i < nf; i++) flt[i] = $urandom % WORDS;
      run_op(($urandom % WORDS) + 1, $urandom % 16, nf, ($urandom % 2) == 1,
             ($urandom % 5) == 0, ($urandom % 3) == 0);
    end
    if (hung) chk(0, "watchdog expired", cyc, 150000);
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule